// File: doc/BRIEF.md
# Triggered Strobe Burst and Counting Gate Generator

This block produces two timing outputs for a multichannel counting system and runs in that system's clock. A rising edge on the start trigger begins a finite burst on the strobe output. The burst is a fixed number of single-cycle pulses spaced a programmable number of cycles apart, and each pulse moves the counter on to its next time bin. When the last period of the burst ends, the strobe output stays low until the next trigger.

The second output is a narrow enable gate for the counters. Within each strobe period it opens a programmable number of cycles after the strobe and stays open for a programmable number of cycles, so counting is limited to a thin slice of every bin. Software can repeat an acquisition of a repetitive signal and move the gate offset by one gate width each time. The data from these runs then resolves time more finely than the bin period.

A simple write port holds four settings: period, strobe count, gate delay and gate width, all in clock cycles. Each burst takes a copy of the settings when it starts. The block also reports how many triggers it ignored and whether the current settings let the gate run past the end of the period.

Top module: `trig_burst_gen`

## Requirements
- R1: After reset, `strobe_a` and `gate_b` are low, `missed_cnt` is zero and `cfg_err` is low.
- R2: A rising edge of `trig_in` seen at a clock edge while idle starts a burst. The first `strobe_a` pulse is high for the one cycle after that edge. Pulses then repeat every `period` cycles, for `count` pulses in total, and each pulse lasts one cycle.
- R3: Once the last period of a burst has elapsed, `strobe_a` and `gate_b` stay low until a new rising edge of `trig_in`. A level held high does not start another burst.
- R4: Take the strobe cycle as offset 0 of a period. `gate_b` is high at offsets `delay` through `delay+width-1`, and a `width` of 0 gives no gate.
- R5: When `delay+width` exceeds `period`, the gate closes after the last cycle before the next strobe. `cfg_err` is then set at the start of the burst. A burst that starts with a consistent configuration clears it.
- R6: A write during a burst does not change that burst. The new value is used from the next burst onward.
- R7: A rising edge of `trig_in` during a burst is ignored, and `missed_cnt` goes up by one. The counter saturates at its maximum.
- R8: A `period` of 0 acts as 1, which gives a strobe every cycle. With a `count` of 0, a trigger starts nothing and is not counted as missed.
- R9: A cycle with `cfg_we` high writes `cfg_wdata` to the setting chosen by `cfg_addr`: 0 is period, 1 is strobe count, 2 is gate delay, 3 is gate width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the counting system |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Start trigger, synchronous, acts on its rising edge |
| cfg_we | input | 1 | Write enable for the settings |
| cfg_addr | input | 2 | Setting select |
| cfg_wdata | input | 16 | Write data |
| strobe_a | output | 1 | Bin-advance strobe |
| gate_b | output | 1 | Counting enable gate |
| missed_cnt | output | 8 | Count of ignored triggers, saturating |
| cfg_err | output | 1 | Gate exceeds the period in the current burst |

## Verification
The scoreboard predicts both outputs cycle by cycle over every burst and for several idle cycles after it. An off-by-one in the phase counter or the burst length therefore shows up as a strobe that is early, late or extra. Another sequence keeps the trigger high past the end of a burst and then raises it again mid-burst. A level-sensitive start would restart the burst there, and a start that is not blocked while busy would do the same. Two further sequences cover a period rewritten during a burst and a gate that would overrun the period. A design without a settings snapshot changes its spacing in the middle of the burst, and one without truncation keeps the gate open over the next strobe. The zero-period and zero-count corners are also exercised, because a design that does not clamp them locks up or starts bursts it should not.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  localparam int unsigned TBG_CW = 16;
  localparam int unsigned TBG_AW = 2;

  typedef enum logic [TBG_AW-1:0] {
    REG_PERIOD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_DELAY  = 2'd2,
    REG_WIDTH  = 2'd3
  } tbg_reg_e;

  typedef struct packed {
    logic [TBG_CW-1:0] period;
    logic [TBG_CW-1:0] count;
    logic [TBG_CW-1:0] delay;
    logic [TBG_CW-1:0] width;
  } tbg_cfg_t;
endpackage

// File: rtl/tbg_cfg_regs.sv
module tbg_cfg_regs
  import tbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [TBG_AW-1:0] addr,
  input  logic [TBG_CW-1:0] wdata,
  input  logic              load,
  input  logic              busy,
  output tbg_cfg_t          live_o,
  output tbg_cfg_t          shadow_o
);
  tbg_cfg_t live_q, live_d;
  tbg_cfg_t shad_q, shad_d;

  always_comb begin
    live_d = live_q;
    if (we) begin
      unique case (tbg_reg_e'(addr))
        REG_PERIOD: live_d.period = wdata;
        REG_COUNT:  live_d.count  = wdata;
        REG_DELAY:  live_d.delay  = wdata;
        REG_WIDTH:  live_d.width  = wdata;
        default:    live_d        = live_q;
      endcase
    end
  end

  always_comb begin
    shad_d = shad_q;
    if (load) shad_d = live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      shad_q <= '0;
    end else begin
      live_q <= live_d;
      shad_q <= shad_d;
    end
  end

  assign live_o   = live_q;
  assign shadow_o = shad_q;

  // R6: the burst copy stays frozen while a burst runs
  assert_shadow_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> $stable(shad_q));
endmodule

// File: rtl/tbg_burst_seq.sv
module tbg_burst_seq
  import tbg_pkg::*;
#(
  parameter int unsigned MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic [TBG_CW-1:0] live_count,
  input  logic [TBG_CW-1:0] sh_period,
  output logic              start_o,
  output logic              busy_o,
  output logic [TBG_CW-1:0] phase_o,
  output logic              strobe_o,
  output logic [MISS_W-1:0] missed_o
);
  logic              trig_q;
  logic              busy_q, busy_d;
  logic [TBG_CW-1:0] ph_q, ph_d;
  logic [TBG_CW-1:0] rem_q, rem_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              rise, start, miss_ev;
  logic [TBG_CW-1:0] p_last;

  assign rise    = trig_in & ~trig_q;
  assign start   = rise & ~busy_q & (live_count != '0);
  assign miss_ev = rise & busy_q;
  assign p_last  = (sh_period == '0) ? '0 : sh_period - 1'b1;

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    rem_d  = rem_q;
    if (start) begin
      busy_d = 1'b1;
      ph_d   = '0;
      rem_d  = live_count;
    end else if (busy_q) begin
      if (ph_q >= p_last) begin
        ph_d = '0;
        if (rem_q <= 1) busy_d = 1'b0;
        else            rem_d  = rem_q - 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_comb begin
    miss_d = miss_q;
    if (miss_ev && !(&miss_q)) miss_d = miss_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      busy_q <= 1'b0;
      ph_q   <= '0;
      rem_q  <= '0;
      miss_q <= '0;
    end else begin
      trig_q <= trig_in;
      busy_q <= busy_d;
      ph_q   <= ph_d;
      rem_q  <= rem_d;
      miss_q <= miss_d;
    end
  end

  assign start_o  = start;
  assign busy_o   = busy_q;
  assign phase_o  = ph_q;
  assign strobe_o = busy_q && (ph_q == '0);
  assign missed_o = miss_q;

  assert_first_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> strobe_o);
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && sh_period > 1) |=> !strobe_o);
  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> !busy_q);
  assert_missed_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_ev && !(&miss_q)) |=> (miss_q == $past(miss_q) + 1'b1));
endmodule

// File: rtl/tbg_gate.sv
module tbg_gate
  import tbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  logic [TBG_CW-1:0] phase,
  input  tbg_cfg_t          live,
  input  tbg_cfg_t          shadow,
  output logic              gate_o,
  output logic              err_o
);
  logic [TBG_CW:0] sh_end, lv_end, lv_peff, sh_peff;
  logic            err_q, err_d;

  assign sh_end  = {1'b0, shadow.delay} + {1'b0, shadow.width};
  assign lv_end  = {1'b0, live.delay} + {1'b0, live.width};
  assign lv_peff = (live.period == '0) ? 1 : {1'b0, live.period};
  assign sh_peff = (shadow.period == '0) ? 1 : {1'b0, shadow.period};

  always_comb begin
    err_d = err_q;
    if (start) err_d = (lv_end > lv_peff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign gate_o = busy && (phase >= shadow.delay) && ({1'b0, phase} < sh_end);
  assign err_o  = err_q;

  // R5: the gate never reaches past the last offset of a period
  assert_gate_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> ({1'b0, phase} < sh_peff));
  // R4: no gate when the burst copy has zero width
  assert_zero_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow.width == '0) |-> !gate_o);
endmodule

// File: rtl/trig_burst_gen.sv
module trig_burst_gen
  import tbg_pkg::*;
#(
  parameter int unsigned MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              cfg_we,
  input  logic [TBG_AW-1:0] cfg_addr,
  input  logic [TBG_CW-1:0] cfg_wdata,
  output logic              strobe_a,
  output logic              gate_b,
  output logic [MISS_W-1:0] missed_cnt,
  output logic              cfg_err
);
  tbg_cfg_t          live, shadow;
  logic              start, busy;
  logic [TBG_CW-1:0] phase;

  tbg_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(start), .busy(busy), .live_o(live), .shadow_o(shadow)
  );

  tbg_burst_seq #(.MISS_W(MISS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .live_count(live.count),
    .sh_period(shadow.period), .start_o(start), .busy_o(busy), .phase_o(phase),
    .strobe_o(strobe_a), .missed_o(missed_cnt)
  );

  tbg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .phase(phase),
    .live(live), .shadow(shadow), .gate_o(gate_b), .err_o(cfg_err)
  );
endmodule

// File: tb/trig_burst_gen_tb_top.sv
module trig_burst_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_in = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic       strobe_a, gate_b, cfg_err;
  logic [7:0] missed_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  int    q_cyc[$];
  bit    q_a[$];
  bit    q_g[$];
  string q_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trig_burst_gen dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .strobe_a(strobe_a),
    .gate_b(gate_b), .missed_cnt(missed_cnt), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp_v, cyc);
    end
  endtask

  // monitor: pops expected samples as their cycle comes up
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      if (q_cyc[0] == cyc) begin
        check({q_tag[0], " strobe_a"}, int'(strobe_a), int'(q_a[0]));
        check({q_tag[0], " gate_b"}, int'(gate_b), int'(q_g[0]));
      end
      void'(q_cyc.pop_front());
      void'(q_a.pop_front());
      void'(q_g.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic push(input int c, input bit a, input bit g, input string tag);
    q_cyc.push_back(c); q_a.push_back(a); q_g.push_back(g); q_tag.push_back(tag);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[1:0]; cfg_wdata = d[15:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg(input int p, input int n, input int d, input int w);
    wr(0, p); wr(1, n); wr(2, d); wr(3, w);
  endtask

  // raise trigger and push the predicted burst plus trailing idle cycles
  task automatic fire(input int p, input int n, input int d, input int w,
                      input int idle, input string tag);
    int pe;
    int c0;
    pe = (p == 0) ? 1 : p;
    @(negedge clk);
    c0 = cyc;
    trig_in = 1'b1;
    for (int i = 0; i < n * pe; i++) begin
      int ph;
      ph = i % pe;
      push(c0 + 1 + i, ph == 0, (ph >= d) && (ph < d + w), tag);
    end
    for (int i = 0; i < idle; i++) push(c0 + 1 + n * pe + i, 1'b0, 1'b0, tag);
  endtask

  task automatic drain();
    while (q_cyc.size() > 0) @(negedge clk);
  endtask

  task automatic drop();
    @(negedge clk);
    trig_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 strobe_a", int'(strobe_a), 0);
    check("R1 gate_b", int'(gate_b), 0);
    check("R1 missed_cnt", int'(missed_cnt), 0);
    check("R1 cfg_err", int'(cfg_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R9: basic burst, trigger held beyond the end (R3)
    cfg(5, 3, 1, 2);
    fire(5, 3, 1, 2, 6, "R2_R4_R9_R3");
    drain();
    drop();
    check("R3 missed after held level", int'(missed_cnt), 0);
    check("R5 err clean config", int'(cfg_err), 0);

    // R5 truncation: delay 3 width 3 in period 4
    cfg(4, 2, 3, 3);
    fire(4, 2, 3, 3, 3, "R5");
    @(negedge clk);
    check("R5 cfg_err set", int'(cfg_err), 1);
    drop();
    drain();
    cfg(4, 1, 0, 2);
    fire(4, 1, 0, 2, 2, "R5_clear");
    drop();
    drain();
    check("R5 cfg_err cleared", int'(cfg_err), 0);

    // R6 write during burst
    cfg(6, 2, 0, 1);
    fire(6, 2, 0, 1, 2, "R6_during");
    repeat (2) @(negedge clk);
    wr(0, 3);
    drop();
    drain();
    fire(3, 2, 0, 1, 2, "R6_next");
    drop();
    drain();

    // R7 missed trigger mid-burst, then held high to the end (R3)
    cfg(5, 4, 2, 1);
    fire(5, 4, 2, 1, 5, "R7_R3");
    repeat (3) @(negedge clk);
    trig_in = 1'b0;
    repeat (2) @(negedge clk);
    trig_in = 1'b1;
    drain();
    check("R7 missed_cnt", int'(missed_cnt), 1);
    drop();

    // R8 period 0 acts as 1
    cfg(0, 4, 0, 1);
    fire(0, 4, 0, 1, 3, "R8_p0");
    drop();
    drain();
    // R8 count 0 starts nothing; R4 zero width gives no gate
    cfg(4, 0, 0, 2);
    fire(4, 0, 0, 2, 8, "R8_n0");
    drop();
    drain();
    check("R8 n0 not missed", int'(missed_cnt), 1);
    cfg(3, 2, 0, 0);
    fire(3, 2, 0, 0, 2, "R4_w0");
    drop();
    drain();

    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule